// File: doc/BRIEF.md
# Secure Register Access Filter

This block sits on an APB-style register bus in front of a peripheral's register file. It decides, transaction by transaction, whether a Non-secure request may reach certain protected address windows. Each window has its own Non-secure permission bit. The bits live in a small gate register, and only Secure transactions can change that register. When a window's bit is clear, a Non-secure read returns zero and a Non-secure write is dropped. The transfer still ends normally on the bus, with ready high and no error. Nothing is forwarded downstream for it.

Secure transactions and permitted Non-secure transactions pass through with no added cycles: the select, enable, direction, address and write data go downstream, and the downstream read data, ready and error come back. The reset value of the two window permission bits is taken from a strap input. The filter decodes the word address, so the two low byte-address bits have no effect on which window an access falls in.

Top module: `sec_access_filter`

## Requirements
- R1: After reset, a Secure read of the gate register (byte offset 0x8E18) returns `secOverride` in bits 0 and 1 and zero in every other bit.
- R2: A Secure write to the gate register stores data bits 3, 1 and 0. Bit 2 and bits 31:4 always read as zero, whatever value was written.
- R3: A Non-secure read of the gate register returns zero, and a Non-secure write to it leaves it unchanged. No access to the gate register is forwarded downstream. Every such access completes with ready high and no error.
- R4: While gate bit 0 is 0, Non-secure accesses to offsets 0x8E00–0x8E7C and 0x9000–0x93FC are not forwarded. Their reads return zero and they complete with ready high and no error.
- R5: While gate bit 1 is 0, Non-secure accesses to offsets 0x8E80–0x8EBC are denied in the same way.
- R6: The secure-init register (parameter, default 0x8E3C) is governed only by gate bit 3. While bit 3 is 0, Non-secure accesses to it are denied. While bit 3 is 1, they are forwarded, whatever bit 0 holds.
- R7: A forwarded access copies select, enable, direction, address and write data downstream. It returns the downstream read data, ready and error unchanged, including downstream wait states.
- R8: A Secure access to any offset other than the gate register is forwarded, whatever the gate bits hold.
- R9: A Non-secure access outside all protected windows is forwarded.
- R10: Window limits are inclusive, and byte-address bits 1:0 are ignored. 0x8E7F falls in the first window, while 0x8DFC, 0x8EC0, 0x8FFC and 0x9400 fall outside all windows.
- R11: While select is low, the downstream select and enable stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secOverride | input | 1 | Strap; reset value of gate bits 0 and 1 |
| pSel | input | 1 | Upstream select |
| pEnable | input | 1 | Upstream access phase |
| pWrite | input | 1 | Upstream direction, 1 = write |
| nonSecure | input | 1 | Security attribute, 1 = Non-secure |
| pAddr | input | 24 | Upstream byte offset |
| pWdata | input | 32 | Upstream write data |
| pRdata | output | 32 | Read data returned upstream |
| pReady | output | 1 | Transfer complete |
| pSlvErr | output | 1 | Error returned upstream |
| mSel | output | 1 | Downstream select |
| mEnable | output | 1 | Downstream access phase |
| mWrite | output | 1 | Downstream direction |
| mAddr | output | 24 | Downstream byte offset |
| mWdata | output | 32 | Downstream write data |
| mRdata | input | 32 | Downstream read data |
| mReady | input | 1 | Downstream ready |
| mSlvErr | input | 1 | Downstream error |

## Verification
The only state is the gate register, and the port outputs depend on it combinationally. A wrong gate bit therefore shows up in the very next access to an affected window. The downstream select rises where it should stay low, or stays low where it should rise, and the read data is zero instead of the downstream value, or the other way round. A reserved bit that sticks shows up in the next Secure read of the gate register. A Non-secure write that leaks into the gate register shows up in the same way. The reference model in the bench tracks the gate register independently. It compares select, enable, address, data, ready and error on every clock, so any such divergence is reported within one access.

// File: rtl/sraf_pkg.sv
package sraf_pkg;

  // Gate register bit positions (decoded by the window logic).
  localparam int unsigned PERM_W     = 4;
  localparam int unsigned PERM_MICRO = 0;
  localparam int unsigned PERM_RAS   = 1;
  localparam int unsigned PERM_INIT  = 3;

  // Which gate bits hold state, and which take their reset from the strap.
  localparam logic [PERM_W-1:0] PERM_IMPL  = 4'b1011;
  localparam logic [PERM_W-1:0] PERM_STRAP = 4'b0011;

  // Strobes from control to datapath.
  typedef struct packed {
    logic fwd;    // pass this transfer downstream
    logic ctlRd;  // Secure read of the gate register
    logic ctlWr;  // Secure write of the gate register, access phase
  } gateStrobe_t;

endpackage

// File: rtl/sraf_decode.sv
module sraf_decode
  import sraf_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned NUM_WIN = 3,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 24'h008E18,
  parameter logic [ADDR_W-1:0] INIT_OFS = 24'h008E3C,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = {24'h009000, 24'h008E80, 24'h008E00},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = {24'h0093FC, 24'h008EBC, 24'h008E7C},
  parameter logic [NUM_WIN-1:0][1:0]        WIN_BIT = {2'd0, 2'd1, 2'd0}
) (
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic              nonSecure,
  input  logic [ADDR_W-3:0] wordAddr,
  input  logic [PERM_W-1:0] permBits,
  output gateStrobe_t       strobe
);

  localparam int unsigned WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] CTRL_WA = CTRL_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] INIT_WA = INIT_OFS[ADDR_W-1:2];

  logic               ctlHit;
  logic               initHit;
  logic [NUM_WIN-1:0] winDeny;
  logic               nsDenied;

  assign ctlHit  = (wordAddr == CTRL_WA);
  assign initHit = (wordAddr == INIT_WA);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [WA_W-1:0] LO_WA = WIN_LO[w][ADDR_W-1:2];
    localparam logic [WA_W-1:0] HI_WA = WIN_HI[w][ADDR_W-1:2];
    logic inWin;
    assign inWin      = (wordAddr >= LO_WA) && (wordAddr <= HI_WA);
    assign winDeny[w] = inWin && !permBits[WIN_BIT[w]];
  end

  // Most specific match wins: the init register overrides its enclosing window.
  always_comb begin
    if (initHit) nsDenied = !permBits[PERM_INIT];
    else         nsDenied = |winDeny;
  end

  always_comb begin
    strobe.fwd   = pSel && !ctlHit && !(nonSecure && nsDenied);
    strobe.ctlRd = pSel && ctlHit && !nonSecure && !pWrite;
    strobe.ctlWr = pSel && pEnable && ctlHit && !nonSecure && pWrite;
  end

endmodule

// File: rtl/sraf_path.sv
module sraf_path
  import sraf_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secOverride,
  input  gateStrobe_t       strobe,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] pRdata,
  output logic              pReady,
  output logic              pSlvErr,
  output logic              mSel,
  output logic              mEnable,
  output logic              mWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              mReady,
  input  logic              mSlvErr,
  output logic [PERM_W-1:0] permBits
);

  localparam int unsigned PAD_W = DATA_W - PERM_W;

  for (genvar b = 0; b < PERM_W; b++) begin : g_perm
    if (PERM_IMPL[b]) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             q <= PERM_STRAP[b] ? secOverride : 1'b0;
        else if (strobe.ctlWr) q <= pWdata[b];
      end
      assign permBits[b] = q;
    end else begin : g_rsv
      assign permBits[b] = 1'b0;
    end
  end

  always_comb begin
    mSel    = strobe.fwd;
    mEnable = strobe.fwd && pEnable;
    mWrite  = strobe.fwd && pWrite;
    mAddr   = strobe.fwd ? pAddr  : '0;
    mWdata  = strobe.fwd ? pWdata : '0;
  end

  always_comb begin
    if (strobe.fwd) begin
      pRdata  = mRdata;
      pReady  = mReady;
      pSlvErr = mSlvErr;
    end else begin
      pRdata  = strobe.ctlRd ? {{PAD_W{1'b0}}, permBits} : '0;
      pReady  = 1'b1;
      pSlvErr = 1'b0;
    end
  end

endmodule

// File: rtl/sec_access_filter.sv
module sec_access_filter
  import sraf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 24'h008E18,
  parameter logic [ADDR_W-1:0] INIT_OFS = 24'h008E3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secOverride,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic              nonSecure,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] pRdata,
  output logic              pReady,
  output logic              pSlvErr,
  output logic              mSel,
  output logic              mEnable,
  output logic              mWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              mReady,
  input  logic              mSlvErr
);

  gateStrobe_t       strobe;
  logic [PERM_W-1:0] permBits;

  sraf_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .INIT_OFS(INIT_OFS)
  ) u_decode (
    .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .nonSecure(nonSecure),
    .wordAddr(pAddr[ADDR_W-1:2]), .permBits(permBits), .strobe(strobe)
  );

  sraf_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .secOverride(secOverride), .strobe(strobe),
    .pEnable(pEnable), .pWrite(pWrite), .pAddr(pAddr), .pWdata(pWdata),
    .pRdata(pRdata), .pReady(pReady), .pSlvErr(pSlvErr),
    .mSel(mSel), .mEnable(mEnable), .mWrite(mWrite), .mAddr(mAddr),
    .mWdata(mWdata), .mRdata(mRdata), .mReady(mReady), .mSlvErr(mSlvErr),
    .permBits(permBits)
  );

endmodule

// File: rtl/sraf_checker.sv
module sraf_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 24'h008E18,
  parameter logic [ADDR_W-1:0] INIT_OFS = 24'h008E3C
) (
  input logic              clk,
  input logic              rstN,
  input logic              pSel,
  input logic              pEnable,
  input logic              pWrite,
  input logic              nonSecure,
  input logic [ADDR_W-1:0] pAddr,
  input logic [DATA_W-1:0] pRdata,
  input logic              pReady,
  input logic              pSlvErr,
  input logic              mSel,
  input logic              mEnable,
  input logic [DATA_W-1:0] mRdata,
  input logic              mReady,
  input logic [3:0]        permBits
);

  logic isCtl, isInit, inFirst;
  assign isCtl   = pAddr[ADDR_W-1:2] == CTRL_OFS[ADDR_W-1:2];
  assign isInit  = pAddr[ADDR_W-1:2] == INIT_OFS[ADDR_W-1:2];
  assign inFirst = (pAddr >= 24'h008E00) && (pAddr <= 24'h008E7F);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !pSel |-> (!mSel && !mEnable));

  a_r3_ctl_local: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && isCtl) |-> (!mSel && pReady && !pSlvErr));

  a_r3_ns_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pWrite && nonSecure && isCtl) |=> $stable(permBits));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pWrite && !nonSecure && isCtl) |->
      (pRdata[DATA_W-1:4] == '0 && !pRdata[2]));

  a_r4_first_window_denied: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && nonSecure && inFirst && !isCtl && !isInit && !permBits[0])
      |-> (!mSel && pRdata == '0 && pReady && !pSlvErr));

  a_r8_secure_forwarded: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && !nonSecure && !isCtl) |-> mSel);

  a_r7_response_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    mSel |-> (pReady == mReady && pRdata == mRdata));

endmodule

bind sec_access_filter sraf_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .INIT_OFS(INIT_OFS)
) u_sraf_checker (
  .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
  .nonSecure(nonSecure), .pAddr(pAddr), .pRdata(pRdata), .pReady(pReady),
  .pSlvErr(pSlvErr), .mSel(mSel), .mEnable(mEnable), .mRdata(mRdata),
  .mReady(mReady), .permBits(permBits)
);

// File: tb/test_sec_access_filter.sv
module test_sec_access_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secOverride = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0, nonSecure = 1'b0;
  logic [23:0] pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic        pReady, pSlvErr;
  logic        mSel, mEnable, mWrite;
  logic [23:0] mAddr;
  logic [31:0] mWdata;
  logic [31:0] mRdata;
  logic        mReady = 1'b1, mSlvErr = 1'b0;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R11";
  logic [3:0] refGate = 4'h0;

  always #5 clk = ~clk;

  // Downstream register file stand-in: data is a function of the address.
  assign mRdata = {8'hC3, mAddr};

  sec_access_filter i_sec_access_filter (
    .clk(clk), .rstN(rstN), .secOverride(secOverride),
    .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .nonSecure(nonSecure),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady),
    .pSlvErr(pSlvErr), .mSel(mSel), .mEnable(mEnable), .mWrite(mWrite),
    .mAddr(mAddr), .mWdata(mWdata), .mRdata(mRdata), .mReady(mReady),
    .mSlvErr(mSlvErr)
  );

  // Reference model of the gate register, from R1..R3.
  function automatic bit isCtlAddr(logic [23:0] a);
    return (a >> 2) == (24'h008E18 >> 2);
  endfunction

  function automatic bit nsBlocked(logic [23:0] a, logic [3:0] g);
    int unsigned w = a >> 2;
    if (w == (24'h008E3C >> 2)) return !g[3];
    if (w >= (24'h008E00 >> 2) && w <= (24'h008E7C >> 2)) return !g[0];
    if (w >= (24'h009000 >> 2) && w <= (24'h0093FC >> 2)) return !g[0];
    if (w >= (24'h008E80 >> 2) && w <= (24'h008EBC >> 2)) return !g[1];
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) refGate <= {2'b00, secOverride, secOverride};
    else if (pSel && pEnable && pWrite && !nonSecure && isCtlAddr(pAddr))
      refGate <= {pWdata[3], 1'b0, pWdata[1], pWdata[0]};
  end

  task automatic chk(string field, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, field, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the rising edge.
  always @(negedge clk) begin
    #3;
    if (rstN) begin
      bit ctl, fwd;
      logic [31:0] expRd;
      ctl = isCtlAddr(pAddr);
      fwd = pSel && !ctl && !(nonSecure && nsBlocked(pAddr, refGate));
      chk("mSel", {31'b0, mSel}, {31'b0, fwd});
      chk("mEnable", {31'b0, mEnable}, {31'b0, fwd && pEnable});
      if (fwd) begin
        chk("mWrite", {31'b0, mWrite}, {31'b0, pWrite});
        chk("mAddr", {8'b0, mAddr}, {8'b0, pAddr});
        if (pWrite) chk("mWdata", mWdata, pWdata);
      end
      if (pSel && pEnable) begin
        chk("pReady", {31'b0, pReady}, {31'b0, fwd ? mReady : 1'b1});
        chk("pSlvErr", {31'b0, pSlvErr}, {31'b0, fwd ? mSlvErr : 1'b0});
        if (!pWrite) begin
          if (fwd)                   expRd = {8'hC3, pAddr};
          else if (ctl && !nonSecure) expRd = {28'b0, refGate};
          else                       expRd = 32'h0;
          if (!fwd || mReady) chk("pRdata", pRdata, expRd);
        end
      end
    end
  end

  task automatic txn(string req, bit ns, bit wr, logic [23:0] a,
                     logic [31:0] d, int waits, bit err);
    @(negedge clk);
    curReq = req;
    pSel = 1'b1; pEnable = 1'b0; pWrite = wr; nonSecure = ns;
    pAddr = a; pWdata = d; mSlvErr = err; mReady = (waits == 0);
    @(negedge clk);
    pEnable = 1'b1;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      if (i == waits - 1) mReady = 1'b1;
    end
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; mSlvErr = 1'b0; mReady = 1'b1;
    curReq = "R11";
  endtask

  task automatic doReset(bit strap);
    @(negedge clk);
    rstN = 1'b0; secOverride = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: strap high, then low
    doReset(1'b1);
    txn("R1", 0, 0, 24'h008E18, 0, 0, 0);
    txn("R3", 1, 0, 24'h008E18, 0, 0, 0);
    doReset(1'b0);
    txn("R1", 0, 0, 24'h008E18, 0, 0, 0);
    repeat (3) @(negedge clk);               // R11 idle
    // R2: reserved bits stay zero
    txn("R2", 0, 1, 24'h008E18, 32'hFFFF_FFFF, 0, 0);
    txn("R2", 0, 0, 24'h008E1B, 0, 0, 0);
    txn("R2", 0, 1, 24'h008E18, 32'h0000_0000, 0, 0);
    txn("R2", 0, 0, 24'h008E18, 0, 0, 0);
    // R3: Non-secure write to gate ignored
    txn("R3", 1, 1, 24'h008E18, 32'h0000_000F, 0, 0);
    txn("R3", 0, 0, 24'h008E18, 0, 0, 0);
    // all permissions clear: R4, R5, R6, R10
    txn("R4", 1, 0, 24'h008E00, 0, 0, 0);
    txn("R4", 1, 1, 24'h009000, 32'h1234_5678, 0, 0);
    txn("R4", 1, 0, 24'h0093FC, 0, 0, 0);
    txn("R10", 1, 0, 24'h008E7F, 0, 0, 0);
    txn("R5", 1, 0, 24'h008E80, 0, 0, 0);
    txn("R5", 1, 1, 24'h008EBC, 32'hDEAD_BEEF, 0, 0);
    txn("R6", 1, 0, 24'h008E3C, 0, 0, 0);
    txn("R9", 1, 0, 24'h008EC0, 0, 0, 0);
    txn("R10", 1, 0, 24'h008FFC, 0, 0, 0);
    txn("R10", 1, 0, 24'h009400, 0, 0, 0);
    txn("R10", 1, 0, 24'h008DFC, 0, 0, 0);
    txn("R9", 1, 1, 24'h000010, 32'hA5A5_0001, 0, 0);
    // R8: Secure always forwarded
    txn("R8", 0, 0, 24'h008E00, 0, 0, 0);
    txn("R8", 0, 1, 24'h008E84, 32'h0BAD_F00D, 0, 0);
    txn("R8", 0, 0, 24'h008E3C, 0, 0, 0);
    txn("R8", 0, 0, 24'h009200, 0, 0, 0);
    // bit 0 only: first windows open, init and RAS still closed
    txn("R2", 0, 1, 24'h008E18, 32'h0000_0001, 0, 0);
    txn("R7", 1, 0, 24'h008E00, 0, 0, 0);
    txn("R7", 1, 1, 24'h0093FC, 32'h7777_0000, 0, 0);
    txn("R6", 1, 0, 24'h008E3C, 0, 0, 0);
    txn("R5", 1, 0, 24'h008EA0, 0, 0, 0);
    // bit 3 only: init open, enclosing window closed
    txn("R2", 0, 1, 24'h008E18, 32'h0000_0008, 0, 0);
    txn("R6", 1, 1, 24'h008E3C, 32'h0000_00AA, 0, 0);
    txn("R6", 1, 0, 24'h008E3C, 0, 0, 0);
    txn("R4", 1, 0, 24'h008E40, 0, 0, 0);
    // bit 1 only
    txn("R2", 0, 1, 24'h008E18, 32'h0000_0002, 0, 0);
    txn("R5", 1, 0, 24'h008EBC, 0, 0, 0);
    txn("R4", 1, 0, 24'h009004, 0, 0, 0);
    // R7: wait states and downstream error
    txn("R7", 1, 0, 24'h008E90, 0, 2, 1);
    txn("R7", 0, 1, 24'h000100, 32'h5555_AAAA, 3, 0);
    txn("R7", 1, 0, 24'h000200, 0, 1, 1);
    repeat (3) @(negedge clk);               // R11 idle
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule